// File: doc/BRIEF.md
# Flag-Producing 8-bit Arithmetic and Logic Unit

This block is the arithmetic core of a small accumulator machine. Two operands, an operation code and the live carry enter. The unit returns the result byte, which is also the new accumulator value, and a high byte that only the multiplier fills. It also returns the next values of the carry (C), overflow (V) and zero (Z) flags. A three-bit flag register inside the block loads those next values on any cycle where `exec_i` is high, and the held flags come back out.

Carry uses a no-borrow convention: after a subtraction C is 1 when no borrow occurred. Increment, decrement and two's complement derive C from a test on the result. The chained variants of these take the incoming carry as a "+C" or "-(1-C)" term, so multi-byte counters and negations can be built a byte at a time. Compare produces the reversed-operand difference and folds the result into V as "strictly greater".

The datapath width, the adder style (behavioural or rippled bit by bit) and the multiplier style (behavioural or a partial-product array) are parameters.

Top module: `flag_alu8`

## Requirements
- R1: Operation codes on `op_i` are:
  - 0 add, 1 add with carry
  - 2 B−A, 3 B−A with borrow, 4 A−B, 5 A−B with borrow
  - 6 increment, 7 increment with carry, 8 decrement, 9 decrement with carry
  - 10 one's complement, 11 two's complement, 12 two's complement with carry
  - 13 and, 14 or, 15 xor
  - 16 shift left, 17 shift left through carry, 18 shift right, 19 shift right through carry, 20 arithmetic shift right
  - 21 compare, 22 multiply

  `hi_o` is zero for every code except multiply. Codes 23–31 return A unchanged, with C taken from `cin_i` and V and Z held.
- R2: For every code 0–21, next Z is 1 exactly when the result byte is zero.
- R3: Add gives A+B, and add with carry gives A+B+C. C is the unsigned carry-out. V is set when A and B share a sign and the result sign differs.
- R4: The subtract codes give B−A or A−B. The borrow variants subtract a further (1−C). C is 0 on unsigned underflow and 1 otherwise. V is the signed overflow of the subtraction.
- R5: Increment gives A+1 with C=1 only when the result is 0x00. Increment with carry gives A+C with C=1 only when the result is 0x00 and C was 1. V is set on a signed overflow.
- R6: Decrement gives A−1 with C=0 only when the result is 0xFF. Decrement with carry gives A−(1−C) with C=0 only when the result is 0xFF and C was 0. V is set on a signed overflow.
- R7: One's complement gives NOT A. Two's complement gives NOT A+1 with C=1 only on a 0x00 result. Its carry form gives NOT A+C with C=1 only on a 0x00 result with C=1. V flags the signed overflow of the negation.
- R8: And, or, xor and one's complement change only Z. Next C equals `cin_i` and next V equals the held V flag.
- R9: Shifts:
  - Left shifts move bit 7 into C and fill bit 0 with 0, or with C for the through-carry form.
  - Right shifts move bit 0 into C and fill bit 7 with 0, with C, or with A bit 7 for the arithmetic form.
  - V is 1 when the result's bit 7 differs from A's bit 7.
- R10: Compare outputs B−A with the subtract carry and sets V to C AND NOT Z.
- R11: Multiply is unsigned. Product bits 7:0 go to `acc_o` and bits 15:8 to `hi_o`. Next C equals `cin_i`, and V and Z are held.
- R12: The flag register clears to zero under reset. It loads the three next-flag outputs at a rising edge with `exec_i` high and holds them otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the flag register |
| exec_i | input | 1 | Load next flags into the flag register |
| op_i | input | 5 | Operation code (R1) |
| opa_i | input | DATA_W | Operand A |
| opb_i | input | DATA_W | Operand B |
| cin_i | input | 1 | Incoming carry |
| acc_o | output | DATA_W | Result byte / new accumulator |
| hi_o | output | DATA_W | High product byte |
| c_nxt_o | output | 1 | Next carry flag |
| v_nxt_o | output | 1 | Next overflow flag |
| z_nxt_o | output | 1 | Next zero flag |
| c_q_o | output | 1 | Held carry flag |
| v_q_o | output | 1 | Held overflow flag |
| z_q_o | output | 1 | Held zero flag |

## Verification
The hardest condition to reach is the one where logic, multiply and unused codes must pass the held V and Z through. Those outputs depend on what the flag register last captured, not on the operands in front of the unit. The stimulus therefore first runs a short chain of executed operations that leaves V at 1 and Z at 0, and only then sweeps every operand pattern. This way a design that recomputes or clears those flags shows a mismatch. The operand sweep runs each A value against a set of B values that includes 0x00, 0x7F, 0x80 and 0xFF, under both carry-in values, so that every borrow and sign boundary is crossed.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUBD  = 5'd2,
      OP_SUBDC = 5'd3,
      OP_SUBS  = 5'd4,
      OP_SUBSC = 5'd5,
      OP_INC   = 5'd6,
      OP_INCC  = 5'd7,
      OP_DEC   = 5'd8,
      OP_DECC  = 5'd9,
      OP_CPL1  = 5'd10,
      OP_CPL2  = 5'd11,
      OP_CPL2C = 5'd12,
      OP_AND   = 5'd13,
      OP_OR    = 5'd14,
      OP_XOR   = 5'd15,
      OP_SHL   = 5'd16,
      OP_SHLC  = 5'd17,
      OP_SHR   = 5'd18,
      OP_SHRC  = 5'd19,
      OP_SHRA  = 5'd20,
      OP_CMP   = 5'd21,
      OP_MUL   = 5'd22
   } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// Shared adder: every add, subtract, step and negate maps onto x + y + ci.
module alu8_addsub import alu8_pkg::*; #(
   parameter int W         = 8,
   parameter int ADD_STYLE = 0
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           cin,
   output logic [W-1:0]   sum,
   output logic           cout,
   output logic           ovf,
   output logic           hit
);
   localparam logic [W-1:0] ALL_ONE  = '1;
   localparam logic [W-1:0] ALL_ZERO = '0;

   logic [W-1:0] x, y;
   logic         ci;
   logic [W:0]   wide;

   always_comb begin
      x   = a;
      y   = ALL_ZERO;
      ci  = 1'b0;
      hit = 1'b1;
      unique case (op)
         OP_ADD:          y = b;
         OP_ADDC:   begin y = b;                   ci = cin;  end
         OP_SUBD,
         OP_CMP:    begin x = b;  y = ~a;          ci = 1'b1; end
         OP_SUBDC:  begin x = b;  y = ~a;          ci = cin;  end
         OP_SUBS:   begin         y = ~b;          ci = 1'b1; end
         OP_SUBSC:  begin         y = ~b;          ci = cin;  end
         OP_INC:                                    ci = 1'b1;
         OP_INCC:                                   ci = cin;
         OP_DEC:          y = ALL_ONE;
         OP_DECC:   begin y = ALL_ONE;             ci = cin;  end
         OP_CPL2:   begin x = ~a;                  ci = 1'b1; end
         OP_CPL2C:  begin x = ~a;                  ci = cin;  end
         default:         hit = 1'b0;
      endcase
   end

   generate
      if (ADD_STYLE == 0) begin : g_fast
         assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      end else begin : g_ripple
         logic [W:0]   cy;
         logic [W-1:0] s;
         assign cy[0] = ci;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign s[i]    = x[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
         end
         assign wide = {cy[W], s};
      end
   endgenerate

   assign sum  = wide[W-1:0];
   assign cout = wide[W];
   assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/1ps
// Bitwise operations and single-bit shifts.
module alu8_bitops import alu8_pkg::*; #(
   parameter int W = 8
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           cin,
   output logic [W-1:0]   res,
   output logic           cout,
   output logic           ovf,
   output logic           hit,
   output logic           keep_cv
);
   always_comb begin
      res     = a;
      cout    = cin;
      hit     = 1'b1;
      keep_cv = 1'b0;
      unique case (op)
         OP_CPL1: begin res = ~a;    keep_cv = 1'b1; end
         OP_AND:  begin res = a & b; keep_cv = 1'b1; end
         OP_OR:   begin res = a | b; keep_cv = 1'b1; end
         OP_XOR:  begin res = a ^ b; keep_cv = 1'b1; end
         OP_SHL:  begin res = {a[W-2:0], 1'b0};    cout = a[W-1]; end
         OP_SHLC: begin res = {a[W-2:0], cin};     cout = a[W-1]; end
         OP_SHR:  begin res = {1'b0, a[W-1:1]};    cout = a[0];   end
         OP_SHRC: begin res = {cin, a[W-1:1]};     cout = a[0];   end
         OP_SHRA: begin res = {a[W-1], a[W-1:1]};  cout = a[0];   end
         default: hit = 1'b0;
      endcase
   end

   // sign change across the shift
   assign ovf = res[W-1] ^ a[W-1];
endmodule

// File: rtl/alu8_mult.sv
`timescale 1ns/1ps
// Unsigned W x W multiplier, behavioural or partial-product array.
module alu8_mult #(
   parameter int W         = 8,
   parameter int MUL_STYLE = 1
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   output logic [2*W-1:0]   prod
);
   localparam int PW = 2 * W;

   generate
      if (MUL_STYLE == 0) begin : g_beh
         assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      end else begin : g_array
         logic [PW-1:0] pp [W];
         for (genvar i = 0; i < W; i++) begin : g_pp
            assign pp[i] = b[i] ? ({{W{1'b0}}, a} << i) : {PW{1'b0}};
         end
         always_comb begin
            prod = '0;
            for (int k = 0; k < W; k++) begin
               prod = prod + pp[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/alu8_flagreg.sv
`timescale 1ns/1ps
// Held C, V, Z flags.
module alu8_flagreg (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load,
   input  logic c_d,
   input  logic v_d,
   input  logic z_d,
   output logic c_q,
   output logic v_q,
   output logic z_q
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         c_q <= 1'b0;
         v_q <= 1'b0;
         z_q <= 1'b0;
      end else if (load) begin
         c_q <= c_d;
         v_q <= v_d;
         z_q <= z_d;
      end
   end
endmodule

// File: rtl/flag_alu8.sv
`timescale 1ns/1ps
module flag_alu8 import alu8_pkg::*; #(
   parameter int DATA_W    = 8,
   parameter int ADD_STYLE = 0,
   parameter int MUL_STYLE = 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               exec_i,
   input  logic [OP_W-1:0]    op_i,
   input  logic [DATA_W-1:0]  opa_i,
   input  logic [DATA_W-1:0]  opb_i,
   input  logic               cin_i,
   output logic [DATA_W-1:0]  acc_o,
   output logic [DATA_W-1:0]  hi_o,
   output logic               c_nxt_o,
   output logic               v_nxt_o,
   output logic               z_nxt_o,
   output logic               c_q_o,
   output logic               v_q_o,
   output logic               z_q_o
);
   localparam int PW = 2 * DATA_W;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("flag_alu8: DATA_W must be at least 2");
      end
      if (ADD_STYLE < 0 || ADD_STYLE > 1) begin : g_bad_add
         $error("flag_alu8: ADD_STYLE must be 0 or 1");
      end
      if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_mul
         $error("flag_alu8: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   alu_op_e op_e;
   assign op_e = alu_op_e'(op_i);

   logic [DATA_W-1:0] as_sum, bo_res;
   logic              as_cout, as_ovf, as_hit;
   logic              bo_cout, bo_ovf, bo_hit, bo_keep;
   logic [PW-1:0]     prod;

   alu8_addsub #(.W(DATA_W), .ADD_STYLE(ADD_STYLE)) u_addsub (
      .op(op_e), .a(opa_i), .b(opb_i), .cin(cin_i),
      .sum(as_sum), .cout(as_cout), .ovf(as_ovf), .hit(as_hit)
   );

   alu8_bitops #(.W(DATA_W)) u_bitops (
      .op(op_e), .a(opa_i), .b(opb_i), .cin(cin_i),
      .res(bo_res), .cout(bo_cout), .ovf(bo_ovf), .hit(bo_hit), .keep_cv(bo_keep)
   );

   alu8_mult #(.W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_mult (
      .a(opa_i), .b(opb_i), .prod(prod)
   );

   always_comb begin
      // default: pass A, carry follows cin, V and Z held
      acc_o   = opa_i;
      hi_o    = '0;
      c_nxt_o = cin_i;
      v_nxt_o = v_q_o;
      z_nxt_o = z_q_o;
      if (as_hit) begin
         acc_o   = as_sum;
         c_nxt_o = as_cout;
         z_nxt_o = (as_sum == '0);
         if (op_e == OP_CMP) v_nxt_o = as_cout & ~(as_sum == '0);
         else                v_nxt_o = as_ovf;
      end else if (bo_hit) begin
         acc_o   = bo_res;
         z_nxt_o = (bo_res == '0);
         if (!bo_keep) begin
            c_nxt_o = bo_cout;
            v_nxt_o = bo_ovf;
         end
      end else if (op_e == OP_MUL) begin
         acc_o = prod[DATA_W-1:0];
         hi_o  = prod[PW-1:DATA_W];
      end
   end

   alu8_flagreg u_flags (
      .clk_i(clk_i), .rst_ni(rst_ni), .load(exec_i),
      .c_d(c_nxt_o), .v_d(v_nxt_o), .z_d(z_nxt_o),
      .c_q(c_q_o), .v_q(v_q_o), .z_q(z_q_o)
   );
endmodule

// File: rtl/alu8_chk.sv
`timescale 1ns/1ps
module alu8_chk import alu8_pkg::*; #(
   parameter int W = 8
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            exec_i,
   input logic [OP_W-1:0] op_i,
   input logic [W-1:0]    opa_i,
   input logic [W-1:0]    opb_i,
   input logic            cin_i,
   input logic [W-1:0]    acc_o,
   input logic [W-1:0]    hi_o,
   input logic            c_nxt_o,
   input logic            v_nxt_o,
   input logic            z_nxt_o,
   input logic            c_q_o,
   input logic            v_q_o,
   input logic            z_q_o
);
   assert_hi_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i != OP_MUL) |-> (hi_o == '0));

   assert_zero_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i < OP_MUL) |-> (z_nxt_o == (acc_o == '0)));

   assert_add_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_ADD) |-> (({1'b0, opa_i} + {1'b0, opb_i}) == {c_nxt_o, acc_o}));

   assert_sub_noborrow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_SUBS) |-> (c_nxt_o == (opa_i >= opb_i)));

   assert_inc_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_INC) |-> (c_nxt_o == (acc_o == '0)));

   assert_dec_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_DEC) |-> (c_nxt_o == (acc_o != '1)));

   assert_negate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_CPL2) |-> (W'(acc_o + opa_i) == '0));

   assert_logic_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_CPL1)
      |-> (c_nxt_o == cin_i && v_nxt_o == v_q_o));

   assert_shra_sign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_SHRA) |-> (acc_o[W-1] == opa_i[W-1] && c_nxt_o == opa_i[0]));

   assert_cmp_v_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_CMP) |-> (v_nxt_o == (c_nxt_o && !z_nxt_o)));

   assert_mul_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_MUL) |-> (z_nxt_o == z_q_o && v_nxt_o == v_q_o && c_nxt_o == cin_i));

   assert_flag_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i |=> (c_q_o == $past(c_nxt_o) && v_q_o == $past(v_nxt_o)
                  && z_q_o == $past(z_nxt_o)));

   assert_flag_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !exec_i |=> ($stable(c_q_o) && $stable(v_q_o) && $stable(z_q_o)));
endmodule

bind flag_alu8 alu8_chk #(.W(DATA_W)) u_alu8_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i),
   .opa_i(opa_i), .opb_i(opb_i), .cin_i(cin_i), .acc_o(acc_o), .hi_o(hi_o),
   .c_nxt_o(c_nxt_o), .v_nxt_o(v_nxt_o), .z_nxt_o(z_nxt_o),
   .c_q_o(c_q_o), .v_q_o(v_q_o), .z_q_o(z_q_o)
);

// File: tb/flag_alu8_bench.sv
`timescale 1ns/1ps
module flag_alu8_bench;
   import alu8_pkg::*;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       exec_i = 1'b0;
   logic [4:0] op_i = 5'd0;
   logic [7:0] opa_i = 8'd0, opb_i = 8'd0;
   logic       cin_i = 1'b0;
   logic [7:0] acc_o, hi_o;
   logic       c_nxt_o, v_nxt_o, z_nxt_o, c_q_o, v_q_o, z_q_o;

   int nchk = 0;
   int nbad = 0;
   int mcq = 0, mvq = 0, mzq = 0;   // model of held flags

   flag_alu8 u_flag_alu8 (
      .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i),
      .opa_i(opa_i), .opb_i(opb_i), .cin_i(cin_i), .acc_o(acc_o), .hi_o(hi_o),
      .c_nxt_o(c_nxt_o), .v_nxt_o(v_nxt_o), .z_nxt_o(z_nxt_o),
      .c_q_o(c_q_o), .v_q_o(v_q_o), .z_q_o(z_q_o)
   );

   always #2 clk_i = ~clk_i;

   function automatic int s8(int x);
      return (x >= 128) ? x - 256 : x;
   endfunction

   function automatic int ovr(int s);
      return (s > 127 || s < -128) ? 1 : 0;
   endfunction

   function automatic string req_tag(logic [4:0] op);
      case (op)
         OP_ADD, OP_ADDC:                              return "R3";
         OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC:         return "R4";
         OP_INC, OP_INCC:                              return "R5";
         OP_DEC, OP_DECC:                              return "R6";
         OP_CPL2, OP_CPL2C:                            return "R7";
         OP_CPL1, OP_AND, OP_OR, OP_XOR:               return "R8";
         OP_SHL, OP_SHLC, OP_SHR, OP_SHRC, OP_SHRA:    return "R9";
         OP_CMP:                                       return "R10";
         OP_MUL:                                       return "R11";
         default:                                      return "R1";
      endcase
   endfunction

   task automatic ref_calc(input logic [4:0] op, input int a, input int b, input int c,
                           output int r, output int h, output int cf, output int vf,
                           output int zf);
      int t;
      bit zupd;
      zupd = 1'b1;
      r = a; h = 0; cf = c; vf = mvq; zf = mzq;
      case (op)
         OP_ADD:   begin t = a + b;     r = t & 255; cf = int'(t > 255); vf = ovr(s8(a) + s8(b)); end
         OP_ADDC:  begin t = a + b + c; r = t & 255; cf = int'(t > 255); vf = ovr(s8(a) + s8(b) + c); end
         OP_SUBD, OP_CMP:
                   begin t = b - a;     r = t & 255; cf = int'(t >= 0); vf = ovr(s8(b) - s8(a)); end
         OP_SUBDC: begin t = b - a - (1 - c); r = t & 255; cf = int'(t >= 0);
                         vf = ovr(s8(b) - s8(a) - (1 - c)); end
         OP_SUBS:  begin t = a - b;     r = t & 255; cf = int'(t >= 0); vf = ovr(s8(a) - s8(b)); end
         OP_SUBSC: begin t = a - b - (1 - c); r = t & 255; cf = int'(t >= 0);
                         vf = ovr(s8(a) - s8(b) - (1 - c)); end
         OP_INC:   begin r = (a + 1) & 255; cf = int'(r == 0); vf = ovr(s8(a) + 1); end
         OP_INCC:  begin r = (a + c) & 255; cf = int'(r == 0 && c == 1); vf = ovr(s8(a) + c); end
         OP_DEC:   begin r = (a + 255) & 255; cf = int'(r != 255); vf = ovr(s8(a) - 1); end
         OP_DECC:  begin r = (a + 255 + c) & 255; cf = int'(!(r == 255 && c == 0));
                         vf = ovr(s8(a) - 1 + c); end
         OP_CPL1:  r = 255 - a;
         OP_CPL2:  begin r = (256 - a) & 255; cf = int'(r == 0); vf = ovr(-s8(a)); end
         OP_CPL2C: begin r = (255 - a + c) & 255; cf = int'(r == 0 && c == 1);
                         vf = ovr(s8(255 - a) + c); end
         OP_AND:   r = a & b;
         OP_OR:    r = a | b;
         OP_XOR:   r = a ^ b;
         OP_SHL:   begin r = (a * 2) & 255;       cf = a / 128; end
         OP_SHLC:  begin r = ((a * 2) & 255) | c; cf = a / 128; end
         OP_SHR:   begin r = a / 2;               cf = a % 2; end
         OP_SHRC:  begin r = a / 2 + c * 128;     cf = a % 2; end
         OP_SHRA:  begin r = a / 2 + (a & 128);   cf = a % 2; end
         OP_MUL:   begin t = a * b; r = t & 255; h = t / 256; zupd = 1'b0; end
         default:  zupd = 1'b0;
      endcase
      if (op >= OP_SHL && op <= OP_SHRA) vf = ((r ^ a) / 128) & 1;
      if (op == OP_CMP) vf = int'(cf == 1 && r != 0);
      if (zupd) zf = int'(r == 0);
   endtask

   // drive at the current time, settle, compare the combinational outputs
   task automatic chk_vec(input logic [4:0] op, input int a, input int b, input int c);
      int r, h, cf, vf, zf;
      op_i = op; opa_i = 8'(a); opb_i = 8'(b); cin_i = c[0];
      #1;
      ref_calc(op, a, b, c, r, h, cf, vf, zf);
      nchk++;
      if (int'(acc_o) != r || int'(hi_o) != h || int'(c_nxt_o) != cf || int'(v_nxt_o) != vf) begin
         nbad++;
         $display("FAIL %s op=%0d a=%02h b=%02h cin=%0d: got acc=%02h hi=%02h c=%0d v=%0d, expected acc=%02h hi=%02h c=%0d v=%0d",
                  req_tag(op), op, a, b, c, acc_o, hi_o, c_nxt_o, v_nxt_o, r, h, cf, vf);
      end
      nchk++;
      if (int'(z_nxt_o) != zf) begin
         nbad++;
         $display("FAIL R2 op=%0d a=%02h b=%02h cin=%0d: got z=%0d, expected z=%0d",
                  op, a, b, c, z_nxt_o, zf);
      end
   endtask

   task automatic chk_held(input string tag, input int ec, input int ev, input int ez);
      nchk++;
      if (int'(c_q_o) != ec || int'(v_q_o) != ev || int'(z_q_o) != ez) begin
         nbad++;
         $display("FAIL %s held flags: got c=%0d v=%0d z=%0d, expected c=%0d v=%0d z=%0d",
                  tag, c_q_o, v_q_o, z_q_o, ec, ev, ez);
      end
   endtask

   // one executed operation: outputs checked, then the held flags after the edge (R12)
   task automatic step_exec(input logic [4:0] op, input int a, input int b, input int c);
      int r, h, cf, vf, zf;
      @(negedge clk_i);
      exec_i = 1'b1;
      ref_calc(op, a, b, c, r, h, cf, vf, zf);
      chk_vec(op, a, b, c);
      @(negedge clk_i);
      exec_i = 1'b0;
      chk_held("R12", cf, vf, zf);
      mcq = cf; mvq = vf; mzq = zf;
   endtask

   initial begin
      int bset [20] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h33, 8'h3C, 8'h40, 8'h55, 8'h7E,
                        8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC0, 8'hC3, 8'hF0, 8'hFE, 8'hFF, 8'h5A};
      logic [4:0] bin_ops [11] = '{OP_ADD, OP_ADDC, OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC,
                                   OP_AND, OP_OR, OP_XOR, OP_CMP, OP_MUL};
      logic [4:0] un_ops [12] = '{OP_INC, OP_INCC, OP_DEC, OP_DECC, OP_CPL1, OP_CPL2, OP_CPL2C,
                                  OP_SHL, OP_SHLC, OP_SHR, OP_SHRC, OP_SHRA};

      // reset state (R12)
      repeat (3) @(negedge clk_i);
      chk_held("R12", 0, 0, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk_held("R12", 0, 0, 0);

      // flag register and held-flag paths
      step_exec(OP_ADD, 8'h7F, 8'h01, 0);     // R3 signed overflow: c0 v1 z0
      step_exec(OP_SUBS, 5, 5, 0);            // R4 equal: c1 v0 z1
      @(negedge clk_i);                       // R12 no load without exec
      op_i = OP_ADD; opa_i = 8'hFF; opb_i = 8'h01; cin_i = 1'b0;
      @(negedge clk_i);
      chk_held("R12", mcq, mvq, mzq);
      step_exec(OP_AND, 8'hF0, 8'h0F, 0);     // R8 z1, c from cin, v held
      step_exec(OP_ADD, 8'h7F, 8'h01, 1);     // v1 again
      step_exec(OP_XOR, 8'h3C, 8'h3C, 1);     // R8 v held at 1
      step_exec(OP_MUL, 8'h10, 8'h10, 0);     // R11 z and v held
      step_exec(OP_CMP, 3, 5, 0);             // R10 greater: c1 z0 v1

      // sweeps with V held at 1 and Z held at 0
      @(negedge clk_i);
      #0.5;
      foreach (bin_ops[k]) begin
         for (int a = 0; a < 256; a++) begin
            foreach (bset[j]) begin
               for (int c = 0; c < 2; c++) chk_vec(bin_ops[k], a, bset[j], c);
            end
         end
      end
      foreach (un_ops[k]) begin
         for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 2; c++) chk_vec(un_ops[k], a, 8'h5A, c);
         end
      end
      // unused codes pass A through (R1)
      for (int u = 23; u < 32; u += 8) begin
         for (int a = 0; a < 256; a += 17) chk_vec(5'(u), a, 8'hA5, a & 1);
      end

      // reset in mid-run clears the held flags (R12)
      @(negedge clk_i);
      rst_ni = 1'b0;
      #1;
      chk_held("R12", 0, 0, 0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      nchk++;
      nbad++;
      $display("FAIL watchdog expired: run did not complete");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule